// File: doc/BRIEF.md
# Unique identifier readout register block

This peripheral exposes a 128-bit per-board identifier, fed in on a static input port, to software one 32-bit word at a time. Software writes a control word that holds a byte index and a trigger pattern. If the pattern is valid and the index is in range, the four identifier bytes that start at that byte offset are loaded into a result register, big-endian. Software then reads that register back.

The block sits on a plain 32-bit register bus made of an address, a write enable, write data and read data. The bus decodes a 1 KiB window. Two offsets are live. Every other offset reads as zero and ignores writes. Read data is combinational from the address. A fetch lands at the same clock edge that stores the control write.

Top module: `uid_readout_regs`

## Requirements
- R1: While rst_ni is low, the control register and the result register are both zero. A read of either returns 0x00000000.
- R2: A write to byte offset 0x40 stores the whole written word with bit 1 forced to 0. A read at 0x40 returns that stored value.
- R3: A control write triggers a fetch only when bit 1 is 1 and at least one of bits 15, 13, 11 or 10 (mask 0xAC00) is 1. Any other control write leaves the result register unchanged.
- R4: The fetch index is control bits [31:16]. When the index is 12 or less, the result register gets identifier bytes index..index+3. Byte k is uid_i[127-8k -: 8], and the lowest byte goes to bits [31:24].
- R5: A triggered write with an index above 12 (including 0xFFFF) does not change the result register.
- R6: A write to offset 0x60 is ignored. A read at 0x60 returns the last fetched word.
- R7: A read at any address other than exactly 0x40 or 0x60 returns zero, including misaligned addresses. A write to such an address changes neither register.
- R8: The result of a fetch is readable in the cycle right after the control write's clock edge. Read data follows addr_i with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 10 | Byte address within the 1 KiB window |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| uid_i | input | 128 | Static board identifier, byte 0 in bits [127:120] |

## Verification
The bench uses the default parameters: a 16-byte identifier, a 32-bit data path and a 10-bit address. With these values the last legal index (12) and the first illegal one (13) are both reachable. So is the full 16-bit index field, up to 0xFFFF. Each of the four arm-mask bits is tried alone with the trigger bit, and also without it. Misaligned and unused addresses are exercised inside the window.

// File: rtl/uid_pkg.sv
package uid_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_KEY  = 2'd2
  } reg_sel_e;

  localparam int unsigned TRIG_BIT = 1;
  localparam logic [31:0] ARM_MASK = 32'h0000_AC00;
  localparam int unsigned IDX_LSB  = 16;
endpackage

// File: rtl/uid_addr_dec.sv
module uid_addr_dec #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned CTRL_OFFS = 'h40,
  parameter int unsigned KEY_OFFS  = 'h60
) (
  input  logic [ADDR_W-1:0] addr_i,
  output uid_pkg::reg_sel_e sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(CTRL_OFFS))     sel_o = uid_pkg::SEL_CTRL;
    else if (addr_i == ADDR_W'(KEY_OFFS)) sel_o = uid_pkg::SEL_KEY;
    else                                  sel_o = uid_pkg::SEL_NONE;
  end
endmodule

// File: rtl/uid_fetch.sv
module uid_fetch #(
  parameter int unsigned ID_BYTES = 16,
  parameter int unsigned DATA_W   = 32
) (
  input  logic [DATA_W-1:0]     ctrl_i,
  input  logic [ID_BYTES*8-1:0] uid_i,
  output logic                  fire_o,
  output logic [DATA_W-1:0]     word_o
);
  localparam int unsigned ID_W    = ID_BYTES * 8;
  localparam int unsigned W_BYTES = DATA_W / 8;
  localparam int unsigned MAX_OFF = ID_BYTES - W_BYTES;
  localparam int unsigned IDX_W   = DATA_W - uid_pkg::IDX_LSB;

  logic [IDX_W-1:0]  idx;
  logic              armed;
  logic              in_range;
  logic [DATA_W-1:0] cand [MAX_OFF+1];

  assign idx      = ctrl_i[DATA_W-1:uid_pkg::IDX_LSB];
  assign armed    = ctrl_i[uid_pkg::TRIG_BIT] &&
                    (|(ctrl_i & DATA_W'(uid_pkg::ARM_MASK)));
  assign in_range = idx <= IDX_W'(MAX_OFF);
  assign fire_o   = armed && in_range;

  // one candidate window per legal byte offset, MSB-first
  for (genvar g = 0; g <= MAX_OFF; g++) begin : g_win
    assign cand[g] = uid_i[ID_W-1-8*g -: DATA_W];
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k <= MAX_OFF; k++)
      if (idx == IDX_W'(k)) word_o = cand[k];
  end
endmodule

// File: rtl/uid_readout_regs.sv
module uid_readout_regs #(
  parameter int unsigned ID_BYTES  = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned CTRL_OFFS = 'h40,
  parameter int unsigned KEY_OFFS  = 'h60
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [ID_BYTES*8-1:0] uid_i
);
  uid_pkg::reg_sel_e sel;
  logic              fire;
  logic [DATA_W-1:0] fetch_word;
  logic [DATA_W-1:0] ctrl_q, key_q;
  logic              ctrl_we;

  uid_addr_dec #(
    .ADDR_W(ADDR_W), .CTRL_OFFS(CTRL_OFFS), .KEY_OFFS(KEY_OFFS)
  ) u_dec (
    .addr_i(addr_i), .sel_o(sel)
  );

  uid_fetch #(
    .ID_BYTES(ID_BYTES), .DATA_W(DATA_W)
  ) u_fetch (
    .ctrl_i(wdata_i), .uid_i(uid_i), .fire_o(fire), .word_o(fetch_word)
  );

  assign ctrl_we = wr_en_i && (sel == uid_pkg::SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      key_q  <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wdata_i & ~(DATA_W'(1) << uid_pkg::TRIG_BIT);
      if (fire) key_q <= fetch_word;
    end
  end

  always_comb begin
    unique case (sel)
      uid_pkg::SEL_CTRL: rdata_o = ctrl_q;
      uid_pkg::SEL_KEY:  rdata_o = key_q;
      default:           rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uid_readout_chk.sv
module uid_readout_chk #(
  parameter int unsigned ID_BYTES  = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned CTRL_OFFS = 'h40,
  parameter int unsigned KEY_OFFS  = 'h60
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-1:0]     addr_i,
  input logic                  wr_en_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [ID_BYTES*8-1:0] uid_i,
  input logic [DATA_W-1:0]     ctrl_q,
  input logic [DATA_W-1:0]     key_q
);
  localparam int unsigned MAX_OFF = ID_BYTES - DATA_W / 8;

  logic        ctrl_wr, trig_ok, idx_ok;
  int unsigned idx;
  logic [7:0]  exp_b0;

  assign ctrl_wr = wr_en_i && addr_i == ADDR_W'(CTRL_OFFS);
  assign idx     = int'(wdata_i[DATA_W-1:16]);
  assign trig_ok = wdata_i[1] && (wdata_i[15] | wdata_i[13] | wdata_i[11] | wdata_i[10]);
  assign idx_ok  = idx <= MAX_OFF;
  assign exp_b0  = idx_ok ? 8'(uid_i >> (ID_BYTES*8 - 8 - 8*idx)) : 8'h00;

  always_ff @(posedge clk_i)
    if (!rst_ni) a_reset_zero_r1 : assert (ctrl_q == '0 && key_q == '0);

  p_ctrl_store_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ctrl_q == ($past(wdata_i) & ~DATA_W'(2)));

  p_first_byte_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && trig_ok && idx_ok) |=> key_q[DATA_W-1 -: 8] == $past(exp_b0));

  p_key_hold_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_wr && trig_ok && idx_ok) |=> $stable(key_q));

  p_other_zero_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_W'(CTRL_OFFS) && addr_i != ADDR_W'(KEY_OFFS)) |-> rdata_o == '0);

  p_ctrl_no_trig_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(CTRL_OFFS) |-> !rdata_o[1]);
endmodule

bind uid_readout_regs uid_readout_chk #(
  .ID_BYTES(ID_BYTES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .CTRL_OFFS(CTRL_OFFS), .KEY_OFFS(KEY_OFFS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .uid_i(uid_i),
  .ctrl_q(ctrl_q), .key_q(key_q)
);

// File: tb/sim_uid_readout_regs.sv
`timescale 1ns/1ps
module sim_uid_readout_regs;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [127:0] uid = 128'hA1B2C3D4_E5F60718_293A4B5C_6D7E8F90;

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    done = 1'b0;

  logic [31:0] m_ctrl = '0, m_key = '0;

  always #2 clk = ~clk;

  uid_readout_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .uid_i(uid)
  );

  function automatic logic [7:0] id_byte(int k);
    return uid[127-8*k -: 8];
  endfunction

  function automatic logic [31:0] model_read(logic [9:0] a);
    if (a == 10'h040) return m_ctrl;
    if (a == 10'h060) return m_key;
    return 32'h0;
  endfunction

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0;
      m_key  <= '0;
    end else if (wr_en && addr == 10'h040) begin
      int ix;
      logic [31:0] w;
      ix = int'(wdata[31:16]);
      m_ctrl <= {wdata[31:2], 1'b0, wdata[0]};
      if (wdata[1] && (wdata & 32'h0000_AC00) != 0 && ix <= 12) begin
        w = '0;
        for (int k = 0; k < 4; k++) w = {w[23:0], id_byte(ix + k)};
        m_key <= w;
      end
    end
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", t, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) if (!done) check({tag, " per-cycle"}, rdata, model_read(addr));

  task automatic put(logic [9:0] a, logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic expect_rd(string t, logic [9:0] a, logic [31:0] e);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    check(t, rdata, e);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(posedge clk);
    #1 addr = 10'h040;
    @(negedge clk); check("R1 ctrl in reset", rdata, 32'h0);
    #1 addr = 10'h060;
    @(negedge clk); check("R1 key in reset", rdata, 32'h0);
    #1 rst_n = 1'b1;

    tag = "R4";
    put(10'h040, 32'h0000_AC02);
    expect_rd("R8 key right after write idx0", 10'h060, 32'hA1B2C3D4);
    expect_rd("R2 ctrl trig cleared", 10'h040, 32'h0000_AC00);
    put(10'h040, 32'h000C_AC02);
    expect_rd("R4 idx12 edge", 10'h060, 32'h6D7E8F90);
    put(10'h040, 32'h0005_8002);
    expect_rd("R4 idx5 mask bit15", 10'h060, 32'hF6071829);

    tag = "R3";
    put(10'h040, 32'h0001_2002);
    expect_rd("R3 mask bit13", 10'h060, 32'hB2C3D4E5);
    put(10'h040, 32'h0002_0802);
    expect_rd("R3 mask bit11", 10'h060, 32'hC3D4E5F6);
    put(10'h040, 32'h0003_0402);
    expect_rd("R3 mask bit10", 10'h060, 32'hD4E5F607);
    put(10'h040, 32'h0007_53FF);
    expect_rd("R3 trig without mask", 10'h060, 32'hD4E5F607);
    expect_rd("R2 ctrl stored", 10'h040, 32'h0007_53FD);
    put(10'h040, 32'h0008_AC01);
    expect_rd("R3 mask without trig", 10'h060, 32'hD4E5F607);

    tag = "R5";
    put(10'h040, 32'h000D_AC02);
    expect_rd("R5 idx13 holds", 10'h060, 32'hD4E5F607);
    put(10'h040, 32'hFFFF_FFFF);
    expect_rd("R5 idxFFFF holds", 10'h060, 32'hD4E5F607);
    expect_rd("R2 ctrl all ones minus trig", 10'h040, 32'hFFFF_FFFD);

    tag = "R6";
    put(10'h060, 32'h1234_5678);
    expect_rd("R6 key write ignored", 10'h060, 32'hD4E5F607);

    tag = "R7";
    put(10'h044, 32'h0000_AC02);
    expect_rd("R7 other write no key change", 10'h060, 32'hD4E5F607);
    expect_rd("R7 other write no ctrl change", 10'h040, 32'hFFFF_FFFD);
    put(10'h041, 32'h0000_AC02);
    expect_rd("R7 misaligned write no effect", 10'h060, 32'hD4E5F607);
    expect_rd("R7 read 0x044", 10'h044, 32'h0);
    expect_rd("R7 read 0x041", 10'h041, 32'h0);
    expect_rd("R7 read 0x3FC", 10'h3FC, 32'h0);

    tag = "R1";
    @(posedge clk); #1 rst_n = 1'b0; addr = 10'h060;
    @(negedge clk); check("R1 key after re-reset", rdata, 32'h0);
    #1 addr = 10'h040;
    @(negedge clk); check("R1 ctrl after re-reset", rdata, 32'h0);
    #1 rst_n = 1'b1;
    tag = "R8";
    put(10'h040, 32'h0009_AC02);
    expect_rd("R8 fetch after reset", 10'h060, 32'h3A4B5C6D);

    @(posedge clk); #1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule